// File: doc/BRIEF.md
# Register Write-Status Handshake Tracker

This block sits between a register bus and a timer register bank whose registers need a few cycles to absorb a write. Each tracked register holds its written value as pending, applies it after a fixed latency of `LAT` clock edges, emits a one-cycle applied pulse with the new value, and then raises the register's flag in one of three shared status words. Software polls that flag and acknowledges it by writing 1 to the same bit of the status word, which clears it.

Nine registers are tracked, spread over three status words: a global word, a counter word and a local-timer word. One further register has no flag; a write to it takes effect on the next edge. Because the latency is a fixed parameter, every write completes within a known, bounded number of cycles, so a polling loop with a timeout never trips on a working block.

Top module: `wstat_tracker`

## Requirements
- R1: After reset every pending bit, applied pulse, held value, the direct register and all three status words are 0.
- R2: A write (`wr_en`=1) with `wr_sel` 0..8 selects tracked register `wr_sel`; its pending bit is 1 from the next edge, and exactly `LAT` edges after the write edge the pending bit falls, `applied_o` pulses for one cycle and the register's value slice in `value_o` shows the written data.
- R3: A tracked register's status flag rises on the edge after the one that raised its applied pulse, never earlier.
- R4: Flag positions: global word bits 0, 1, 2 and 16 for selects 0, 1, 2 and 3; counter word bits 0 and 1 for selects 4 and 5; local word bits 0, 1 and 3 for selects 6, 7 and 8.
- R5: A write with select 9, 10 or 11 (global, counter, local status word) clears every flag of that word whose data bit is 1 and leaves the rest; bits of a status word that map to no register always read 0.
- R6: If a flag is being set on the same edge that a clear write hits it, the flag ends up 1.
- R7: A second write to a register that is still pending replaces the held data and restarts its latency; one applied pulse follows, carrying the last data.
- R8: A write with select 12 updates `direct_o` on the next edge and changes no pending bit and no flag.
- R9: Writes with select 13, 14 or 15 change no output.
- R10: A pending bit never stays high for more than `LAT` consecutive cycles without a new write to its register.
- R11: Different tracked registers pend and apply independently; writes on consecutive cycles to different registers each complete `LAT` edges after their own write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 4 | Register select |
| wr_data | input | DW | Write data |
| pend_o | output | 9 | Per-register pending bits |
| applied_o | output | 9 | Per-register one-cycle applied pulse |
| value_o | output | 9*DW | Applied value of each tracked register, register i at bits i*DW upward |
| direct_o | output | DW | Untracked register, applied at once |
| gstat_o | output | DW | Global status word |
| cstat_o | output | DW | Counter status word |
| lstat_o | output | DW | Local status word |

## Verification
The bench aims at the edge where an apply completes and a clear write lands together; a design that let the clear win would lose the acknowledgement and leave software polling until its timeout. It rewrites a register mid-flight, which catches a design that applies the stale value or pulses twice, and it writes all nine registers back to back so a wrong bit position or a shared latency counter shows up as a wrong status word. Writes to the direct register and to the unused selects are checked to leave every flag and pending bit alone.

// File: rtl/wstat_pkg.sv
package wstat_pkg;

    localparam int NTRK  = 9;
    localparam int NGRP  = 3;
    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMP_LO = 4'd0,
        SEL_CMP_HI = 4'd1,
        SEL_INCR   = 4'd2,
        SEL_GCTL   = 4'd3,
        SEL_CNT_LO = 4'd4,
        SEL_CNT_HI = 4'd5,
        SEL_TICKB  = 4'd6,
        SEL_INTB   = 4'd7,
        SEL_LCTL   = 4'd8,
        SEL_GSTAT  = 4'd9,
        SEL_CSTAT  = 4'd10,
        SEL_LSTAT  = 4'd11,
        SEL_DIRECT = 4'd12
    } sel_e;

    // status word that holds the flag of tracked register i
    function automatic int grp_of(input int i);
        if (i < 4)      return 0;
        else if (i < 6) return 1;
        else            return 2;
    endfunction

    // bit position of that flag inside its status word (decoded by software)
    function automatic int bit_of(input int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 16;
            4: return 0;
            5: return 1;
            6: return 0;
            7: return 1;
            default: return 3;
        endcase
    endfunction

    function automatic logic [31:0] grp_mask(input int g);
        case (g)
            0: return 32'h0001_0007;
            1: return 32'h0000_0003;
            default: return 32'h0000_000B;
        endcase
    endfunction

endpackage

// File: rtl/wstat_slot.sv
module wstat_slot #(
    parameter int DW  = 32,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] load_data_i,
    output logic          pend_o,
    output logic          done_o,
    output logic [DW-1:0] value_o
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic          pend;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW-1:0] hold;
        logic [DW-1:0] value;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (load_i) begin
            s_d.pend = 1'b1;
            s_d.cnt  = CW'(LAT - 1);
            s_d.hold = load_data_i;
        end else if (s_q.pend) begin
            if (s_q.cnt == '0) begin
                s_d.pend  = 1'b0;
                s_d.done  = 1'b1;
                s_d.value = s_q.hold;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o  = s_q.pend;
    assign done_o  = s_q.done;
    assign value_o = s_q.value;
endmodule

// File: rtl/wstat_flags.sv
module wstat_flags
    import wstat_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NTRK-1:0]    done_i,
    input  logic [NGRP-1:0]    clr_i,
    input  logic [DW-1:0]      clr_data_i,
    output logic [NGRP*DW-1:0] stat_o
);
    typedef struct packed {
        logic [NGRP-1:0][DW-1:0] w;
    } flags_t;

    flags_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        for (int g = 0; g < NGRP; g++) begin
            if (clr_i[g]) f_d.w[g] = f_q.w[g] & ~clr_data_i;
        end
        // a completing apply overrides a clear on the same edge
        for (int i = 0; i < NTRK; i++) begin
            if (done_i[i]) f_d.w[grp_of(i)][bit_of(i)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign stat_o = f_q.w;
endmodule

// File: rtl/wstat_tracker.sv
module wstat_tracker
    import wstat_pkg::*;
#(
    parameter int DW  = 32,
    parameter int LAT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [DW-1:0]      wr_data,
    output logic [NTRK-1:0]    pend_o,
    output logic [NTRK-1:0]    applied_o,
    output logic [NTRK*DW-1:0] value_o,
    output logic [DW-1:0]      direct_o,
    output logic [DW-1:0]      gstat_o,
    output logic [DW-1:0]      cstat_o,
    output logic [DW-1:0]      lstat_o
);
    typedef struct packed {
        logic [DW-1:0] direct;
    } top_t;

    top_t t_d, t_q;
    logic [NTRK-1:0]    load;
    logic [NGRP-1:0]    clr;
    logic [NGRP*DW-1:0] stat;

    always_comb begin
        t_d = t_q;
        clr = '0;
        if (wr_en) begin
            if (wr_sel == SEL_DIRECT) t_d.direct = wr_data;
            if (wr_sel == SEL_GSTAT)  clr[0] = 1'b1;
            if (wr_sel == SEL_CSTAT)  clr[1] = 1'b1;
            if (wr_sel == SEL_LSTAT)  clr[2] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    for (genvar i = 0; i < NTRK; i++) begin : g_slot
        assign load[i] = wr_en && (wr_sel == SEL_W'(i));
        wstat_slot #(.DW(DW), .LAT(LAT)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load[i]),
            .load_data_i(wr_data),
            .pend_o     (pend_o[i]),
            .done_o     (applied_o[i]),
            .value_o    (value_o[i*DW +: DW])
        );
    end

    wstat_flags #(.DW(DW)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (applied_o),
        .clr_i     (clr),
        .clr_data_i(wr_data),
        .stat_o    (stat)
    );

    assign direct_o = t_q.direct;
    assign gstat_o  = stat[0*DW +: DW];
    assign cstat_o  = stat[1*DW +: DW];
    assign lstat_o  = stat[2*DW +: DW];
endmodule

// File: rtl/wstat_tracker_chk.sv
module wstat_tracker_chk
    import wstat_pkg::*;
#(
    parameter int DW  = 32,
    parameter int LAT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [DW-1:0]    wr_data,
    input logic [NTRK-1:0]  pend_o,
    input logic [NTRK-1:0]  applied_o,
    input logic [DW-1:0]    direct_o,
    input logic [DW-1:0]    gstat_o
);
    localparam int RW = $clog2(LAT + 2);

    for (genvar i = 0; i < NTRK; i++) begin : g_run
        logic [RW-1:0] run_q;
        always_ff @(posedge clk) begin
            if (!rst_n || (wr_en && wr_sel == SEL_W'(i)) || !pend_o[i]) run_q <= '0;
            else run_q <= run_q + 1'b1;
        end
        AST_PEND_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
            pend_o[i] |-> (int'(run_q) < LAT)); // R10
        AST_APPLY_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(applied_o[i]) |-> $past(pend_o[i])); // R2
    end

    AST_FLAG_AFTER_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gstat_o[0]) |-> $past(applied_o[0])); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (gstat_o & ~DW'(grp_mask(0))) == '0); // R5
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_GSTAT && wr_data[0] && !applied_o[0]) |=> !gstat_o[0]); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        applied_o[3] |=> gstat_o[16]); // R6
    AST_DIRECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DIRECT) |=> (direct_o == $past(wr_data))); // R8
endmodule

bind wstat_tracker wstat_tracker_chk #(.DW(DW), .LAT(LAT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .pend_o   (pend_o),
    .applied_o(applied_o),
    .direct_o (direct_o),
    .gstat_o  (gstat_o)
);

// File: tb/wstat_tracker_test.sv
module wstat_tracker_test;
    localparam int DW  = 32;
    localparam int LAT = 3;
    localparam int NT  = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_sel = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NT-1:0] pend_o, applied_o;
    logic [NT*DW-1:0] value_o;
    logic [DW-1:0] direct_o, gstat_o, cstat_o, lstat_o;

    int vectors = 0;
    int fails = 0;
    bit run = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wstat_tracker #(.DW(DW), .LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pend_o(pend_o), .applied_o(applied_o), .value_o(value_o), .direct_o(direct_o),
        .gstat_o(gstat_o), .cstat_o(cstat_o), .lstat_o(lstat_o)
    );

    // behavioural reference
    int          m_rem [NT];
    logic [DW-1:0] m_hold [NT];
    logic [DW-1:0] m_val [NT];
    logic [NT-1:0] m_app;
    logic [DW-1:0] m_stat [3];
    logic [DW-1:0] m_dir;

    function automatic int grp(input int i);
        return (i < 4) ? 0 : (i < 6) ? 1 : 2;
    endfunction
    function automatic int pos(input int i);
        int p [NT] = '{0, 1, 2, 16, 0, 1, 0, 1, 3};
        return p[i];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) begin
                m_rem[i] = 0; m_hold[i] = '0; m_val[i] = '0;
            end
            m_app = '0; m_dir = '0;
            for (int g = 0; g < 3; g++) m_stat[g] = '0;
        end else begin
            if (wr_en && wr_sel >= 9 && wr_sel <= 11) m_stat[wr_sel - 9] &= ~wr_data;
            for (int i = 0; i < NT; i++) if (m_app[i]) m_stat[grp(i)][pos(i)] = 1'b1;
            m_app = '0;
            for (int i = 0; i < NT; i++) begin
                if (wr_en && wr_sel == i) begin
                    m_rem[i] = LAT; m_hold[i] = wr_data;
                end else if (m_rem[i] > 0) begin
                    m_rem[i]--;
                    if (m_rem[i] == 0) begin
                        m_app[i] = 1'b1; m_val[i] = m_hold[i];
                    end
                end
            end
            if (wr_en && wr_sel == 12) m_dir = wr_data;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run) begin
            for (int i = 0; i < NT; i++) begin
                chk("R2 pend", 64'(pend_o[i]), 64'(m_rem[i] > 0));
                chk("R2 applied", 64'(applied_o[i]), 64'(m_app[i]));
                chk("R2 value", 64'(value_o[i*DW +: DW]), 64'(m_val[i]));
            end
            chk("R3 gstat", 64'(gstat_o), 64'(m_stat[0]));
            chk("R3 cstat", 64'(cstat_o), 64'(m_stat[1]));
            chk("R3 lstat", 64'(lstat_o), 64'(m_stat[2]));
            chk("R8 direct", 64'(direct_o), 64'(m_dir));
        end
    end

    task automatic wr(input int sel, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'(sel); wr_data = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(5ns * 20000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [NT*DW-1:0] snap_v;
        logic [DW-1:0] snap_g, snap_c, snap_l, snap_d;
        int cnt;
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pend", 64'(pend_o), 0);
        chk("R1 status", 64'(gstat_o | cstat_o | lstat_o), 0);
        chk("R1 value/direct", 64'(|value_o | |direct_o), 0);
        run = 1'b1;

        // R2 / R10: pending lasts exactly LAT cycles
        wr(0, 32'hA5A5_0001);
        cnt = 0;
        for (int k = 0; k < LAT + 3; k++) begin
            idle(1);
            if (pend_o[0]) cnt++;
        end
        chk("R10 pend length", 64'(cnt), 64'(LAT));
        chk("R2 value after apply", 64'(value_o[0 +: DW]), 64'h0A5A5_0001);
        chk("R3 flag raised", 64'(gstat_o), 64'h1);

        // R4 / R11: back-to-back writes to every tracked register
        for (int i = 0; i < NT; i++) wr(i, 32'h100 + i);
        idle(LAT + 3);
        chk("R4 global word", 64'(gstat_o), 64'h1_0007);
        chk("R4 counter word", 64'(cstat_o), 64'h3);
        chk("R4 local word", 64'(lstat_o), 64'hB);
        chk("R11 last value", 64'(value_o[8*DW +: DW]), 64'h108);

        // R5: write-one-to-clear, zeros leave flags alone
        wr(9, 32'h0001_0001); idle(1);
        chk("R5 clear selected", 64'(gstat_o), 64'h6);
        wr(10, 32'h0); idle(1);
        chk("R5 zero keeps", 64'(cstat_o), 64'h3);
        wr(11, 32'hFFFF_FFFF); idle(1);
        chk("R5 clear all local", 64'(lstat_o), 64'h0);

        // R6: clear lands on the edge where the flag is set
        wr(3, 32'hC0DE);
        idle(LAT);
        wr(9, 32'h0001_0000);
        idle(1);
        chk("R6 set wins", 64'(gstat_o[16]), 64'h1);

        // R7: rewrite while pending
        wr(2, 32'h1111);
        idle(1);
        wr(2, 32'h2222);
        cnt = 0;
        for (int k = 0; k < LAT + 4; k++) begin
            idle(1);
            if (applied_o[2]) cnt++;
        end
        chk("R7 single pulse", 64'(cnt), 64'h1);
        chk("R7 last data", 64'(value_o[2*DW +: DW]), 64'h2222);

        // R8: direct register
        wr(9, 32'hFFFF_FFFF); wr(10, 32'hFFFF_FFFF); idle(1);
        wr(12, 32'hBEEF_0042); idle(1);
        chk("R8 direct value", 64'(direct_o), 64'hBEEF_0042);
        chk("R8 no pend/flag", 64'(|pend_o | |gstat_o | |cstat_o | |lstat_o), 64'h0);

        // R9: unused selects
        snap_v = value_o; snap_g = gstat_o; snap_c = cstat_o; snap_l = lstat_o; snap_d = direct_o;
        wr(13, 32'hDEAD); wr(14, 32'hFFFF_FFFF); wr(15, 32'h1234);
        idle(LAT + 2);
        chk("R9 values", 64'(snap_v != value_o), 64'h0);
        chk("R9 status/direct", 64'({snap_g, snap_c, snap_l, snap_d} != {gstat_o, cstat_o, lstat_o, direct_o}), 64'h0);
        chk("R9 pend", 64'(pend_o), 64'h0);

        run = 1'b0;
        finished = 1'b1;
        finish_run();
    end
endmodule